// File: doc/BRIEF.md
# Accumulator Shift and Multiply Unit

This unit is a sequential datapath with two registers. The first is a 12-bit accumulator (A). The second is an 11-bit extension register (B) that software never addresses directly. For shifts, the two registers act as one 23-bit word with A in the upper part. A left shift pushes the top bit of B into the bottom of A. A right shift sign-extends A and feeds the bit that falls out of A into the top of B. Each shifted bit costs one clock cycle.

The unit also runs an unsigned shift-and-add multiply of A by a 12-bit operand in twelve steps. The product is split: the low 11 bits go to B and the upper bits go to A. Three single-step register operations are also provided: copy A into B, copy B into A, and load A directly from the operand.

A surrounding sequencer presents an opcode, a 5-bit shift count and the operand with a valid strobe. It then waits for `done`. `busy` covers the working cycles, and commands offered before the unit is idle again are dropped.

Top module: `acc_shift_mul_unit`

## Requirements
- R1: While `rst` is high at a rising edge, A, B, the step counter and the phase are cleared. After the edge, `acc_q`=0, `ext_q`=0, `busy`=0 and `done`=0.
- R2: A command is taken at a rising edge where `cmd_valid` is 1 and both `busy` and `done` are 0. The `cmd_op` codes are: 0 no-op, 1 left shift, 2 right shift, 3 multiply, 4 copy A to B, 5 copy B to A, 6 load A, 7 no-op. With `cmd_valid` low, nothing is taken.
- R3: After a command is taken, `busy` is high for one preparation cycle plus one cycle per step. `done` is then high for exactly one cycle, and `busy` and `done` are never high together.
- R4: Left shift by n (1..31): the 23-bit word {A,B} shifts left n times, zero entering bit 0 of B and B bit 10 entering A bit 0. `busy` lasts n+1 cycles.
- R5: Right shift by n (1..31): {A,B} shifts right n times, A bit 11 is replicated and A bit 0 enters B bit 10. `busy` lasts n+1 cycles.
- R6: A shift with count 0 leaves A and B unchanged and keeps `busy` high for one cycle only.
- R7: Multiply with A and operand both below 0x800: the product P=A*operand ends with B=P[10:0] and A=P[21:11], whatever B held before.
- R8: Multiply ignores `cmd_count` and keeps `busy` high for 13 cycles.
- R9: Copy A to B sets B=A[10:0] and leaves A unchanged; `busy` lasts one cycle.
- R10: Copy B to A sets A={1'b0,B} and leaves B unchanged; `busy` lasts one cycle.
- R11: Load sets A to the operand present when the command was taken, and leaves B unchanged.
- R12: A command offered while `busy` or `done` is high is ignored: it neither changes the running result nor starts a new operation.
- R13: Codes 0 and 7 change neither register and complete with one `busy` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Operation code |
| cmd_count | input | 5 | Shift count |
| cmd_operand | input | 12 | Operand for load and multiply |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| acc_q | output | 12 | Accumulator A |
| ext_q | output | 11 | Extension register B |

## Verification
On every cycle, the properties cover the following:
- the reset state;
- the `busy` to `done` handover and the single-cycle `done` pulse;
- rejection of a command offered during `done`;
- the register values after copy, load and zero-count shifts, relative to the values at acceptance.

Shift and multiply results depend on many cycles of history. The bench therefore checks them against a 23-bit word model for varied patterns, including sign fill, counts beyond 23 and pre-filled B before a multiply. It also checks exact `busy` lengths and commands offered in the middle of a shift.

// File: rtl/asm_pkg.sv
package asm_pkg;

    localparam int ACC_W_DEF = 12;
    localparam int EXT_W_DEF = 11;
    localparam int CNT_W_DEF = 5;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_SHL  = 3'd1,
        OP_SHR  = 3'd2,
        OP_MUL  = 3'd3,
        OP_A2B  = 3'd4,
        OP_B2A  = 3'd5,
        OP_LOAD = 3'd6,
        OP_RSVD = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_PREP,
        PH_STEP,
        PH_FIN
    } phase_e;

    typedef struct packed {
        logic prep;
        logic step;
        op_e  op;
    } dp_ctl_t;

    function automatic logic is_shift(op_e op);
        return (op == OP_SHL) || (op == OP_SHR);
    endfunction

endpackage

// File: rtl/asm_ctrl.sv
module asm_ctrl
    import asm_pkg::*;
#(
    parameter int CNT_W     = CNT_W_DEF,
    parameter int MUL_STEPS = ACC_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  op_e              cmd_op,
    input  logic [CNT_W-1:0] cmd_count,
    output logic             accept,
    output dp_ctl_t          ctl,
    output logic             busy,
    output logic             done
);
    localparam int MAX_SHIFT = (1 << CNT_W) - 1;
    localparam int MAX_STEPS = (MAX_SHIFT > MUL_STEPS) ? MAX_SHIFT : MUL_STEPS;
    localparam int STEP_W    = $clog2(MAX_STEPS + 1);

    phase_e            phase;
    op_e               op_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [STEP_W-1:0] left_q;

    assign accept   = (phase == PH_IDLE) && cmd_valid;
    assign busy     = (phase == PH_PREP) || (phase == PH_STEP);
    assign done     = (phase == PH_FIN);
    assign ctl.prep = (phase == PH_PREP);
    assign ctl.step = (phase == PH_STEP);
    assign ctl.op   = op_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            op_q   <= OP_NOP;
            cnt_q  <= '0;
            left_q <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (accept) begin
                        op_q  <= cmd_op;
                        cnt_q <= cmd_count;
                        phase <= PH_PREP;
                    end
                end
                PH_PREP: begin
                    if (op_q == OP_MUL) begin
                        left_q <= STEP_W'(MUL_STEPS);
                        phase  <= PH_STEP;
                    end else if (is_shift(op_q) && (cnt_q != '0)) begin
                        left_q <= STEP_W'(cnt_q);
                        phase  <= PH_STEP;
                    end else begin
                        phase <= PH_FIN;
                    end
                end
                PH_STEP: begin
                    left_q <= left_q - 1'b1;
                    if (left_q == STEP_W'(1)) begin
                        phase <= PH_FIN;
                    end
                end
                PH_FIN: begin
                    phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/asm_datapath.sv
module asm_datapath
    import asm_pkg::*;
#(
    parameter int ACC_W = ACC_W_DEF,
    parameter int EXT_W = EXT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic [ACC_W-1:0] operand,
    input  dp_ctl_t          ctl,
    output logic [ACC_W-1:0] acc,
    output logic [EXT_W-1:0] ext
);
    localparam int W   = ACC_W + EXT_W;
    localparam int PAD = ACC_W - EXT_W;

    logic [ACC_W-1:0] acc_r;
    logic [EXT_W-1:0] ext_r;
    logic [ACC_W-1:0] mcand_r;
    logic [ACC_W-1:0] mreg_r;

    logic [W-1:0] pair;
    logic [W-1:0] shl_v;
    logic [W-1:0] shr_v;
    logic [W-1:0] addend;
    logic [W-1:0] mul_v;

    always_comb begin
        pair   = {acc_r, ext_r};
        shl_v  = {pair[W-2:0], 1'b0};
        shr_v  = {pair[W-1], pair[W-1:1]};
        addend = mreg_r[ACC_W-1] ? {{EXT_W{1'b0}}, mcand_r} : '0;
        mul_v  = shl_v + addend;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_r   <= '0;
            ext_r   <= '0;
            mcand_r <= '0;
            mreg_r  <= '0;
        end else begin
            if (accept) begin
                mreg_r <= operand;
            end
            if (ctl.prep) begin
                unique case (ctl.op)
                    OP_MUL: begin
                        mcand_r <= acc_r;
                        acc_r   <= '0;
                        ext_r   <= '0;
                    end
                    OP_A2B:  ext_r <= acc_r[EXT_W-1:0];
                    OP_B2A:  acc_r <= {{PAD{1'b0}}, ext_r};
                    OP_LOAD: acc_r <= mreg_r;
                    default: ;
                endcase
            end else if (ctl.step) begin
                unique case (ctl.op)
                    OP_SHL: {acc_r, ext_r} <= shl_v;
                    OP_SHR: {acc_r, ext_r} <= shr_v;
                    OP_MUL: begin
                        {acc_r, ext_r} <= mul_v;
                        mreg_r         <= {mreg_r[ACC_W-2:0], 1'b0};
                    end
                    default: ;
                endcase
            end
        end
    end

    assign acc = acc_r;
    assign ext = ext_r;

endmodule

// File: rtl/acc_shift_mul_unit.sv
module acc_shift_mul_unit
    import asm_pkg::*;
#(
    parameter int ACC_W = ACC_W_DEF,
    parameter int EXT_W = EXT_W_DEF,
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [CNT_W-1:0] cmd_count,
    input  logic [ACC_W-1:0] cmd_operand,
    output logic             busy,
    output logic             done,
    output logic [ACC_W-1:0] acc_q,
    output logic [EXT_W-1:0] ext_q
);
    logic    accept;
    dp_ctl_t ctl;

    asm_ctrl #(
        .CNT_W     (CNT_W),
        .MUL_STEPS (ACC_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (op_e'(cmd_op)),
        .cmd_count (cmd_count),
        .accept    (accept),
        .ctl       (ctl),
        .busy      (busy),
        .done      (done)
    );

    asm_datapath #(
        .ACC_W (ACC_W),
        .EXT_W (EXT_W)
    ) u_dp (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .operand (cmd_operand),
        .ctl     (ctl),
        .acc     (acc_q),
        .ext     (ext_q)
    );

endmodule

// File: rtl/asm_unit_chk.sv
module asm_unit_chk #(
    parameter int ACC_W = 12,
    parameter int EXT_W = 11,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_valid,
    input logic [2:0]       cmd_op,
    input logic [CNT_W-1:0] cmd_count,
    input logic [ACC_W-1:0] cmd_operand,
    input logic             busy,
    input logic             done,
    input logic [ACC_W-1:0] acc_q,
    input logic [EXT_W-1:0] ext_q
);
    logic idle;
    logic take;
    assign idle = !busy && !done;
    assign take = idle && cmd_valid;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (acc_q == '0 && ext_q == '0 && !busy && !done));

    // R3
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3
    busy_ends_done_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R12
    done_rejects_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (done && cmd_valid) |=> (!busy && !done));

    // R9
    copy_a2b_chk: assert property (@(posedge clk) disable iff (rst)
        (take && cmd_op == 3'd4) |=> ##1
        (done && ext_q == $past(acc_q[EXT_W-1:0], 2) && acc_q == $past(acc_q, 2)));

    // R10
    copy_b2a_chk: assert property (@(posedge clk) disable iff (rst)
        (take && cmd_op == 3'd5) |=> ##1
        (done && acc_q == {{(ACC_W-EXT_W){1'b0}}, $past(ext_q, 2)} && ext_q == $past(ext_q, 2)));

    // R11
    load_chk: assert property (@(posedge clk) disable iff (rst)
        (take && cmd_op == 3'd6) |=> ##1
        (done && acc_q == $past(cmd_operand, 2) && ext_q == $past(ext_q, 2)));

    // R6
    zero_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (take && (cmd_op == 3'd1 || cmd_op == 3'd2) && cmd_count == '0) |=> ##1
        (done && acc_q == $past(acc_q, 2) && ext_q == $past(ext_q, 2)));

endmodule

bind acc_shift_mul_unit asm_unit_chk #(
    .ACC_W (ACC_W),
    .EXT_W (EXT_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_count   (cmd_count),
    .cmd_operand (cmd_operand),
    .busy        (busy),
    .done        (done),
    .acc_q       (acc_q),
    .ext_q       (ext_q)
);

// File: tb/tb_acc_shift_mul_unit.sv
`timescale 1ns/1ps
module tb_acc_shift_mul_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [4:0]  cmd_count = 5'd0;
    logic [11:0] cmd_operand = 12'd0;
    logic        busy;
    logic        done;
    logic [11:0] acc_q;
    logic [10:0] ext_q;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    acc_shift_mul_unit dut (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .cmd_count   (cmd_count),
        .cmd_operand (cmd_operand),
        .busy        (busy),
        .done        (done),
        .acc_q       (acc_q),
        .ext_q       (ext_q)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Drive one command, return the number of busy cycles; ends at the done cycle.
    task automatic issue(input logic [2:0] op, input logic [4:0] cnt,
                         input logic [11:0] opnd, output int bcyc);
        @(negedge clk);
        cmd_valid   = 1'b1;
        cmd_op      = op;
        cmd_count   = cnt;
        cmd_operand = opnd;
        @(negedge clk);
        cmd_valid = 1'b0;
        bcyc = 0;
        while (busy && bcyc < 100) begin
            bcyc++;
            @(negedge clk);
        end
        check("R3", "done after busy", 32'(done), 32'd1);
    endtask

    task automatic set_ab(input logic [11:0] a, input logic [10:0] b);
        int c;
        issue(3'd6, 5'd0, {1'b0, b}, c);
        issue(3'd4, 5'd0, 12'd0, c);
        issue(3'd6, 5'd0, a, c);
    endtask

    function automatic logic [22:0] model_shift(logic [22:0] v, logic left, int n);
        logic signed [22:0] s;
        s = v;
        if (left) return v << n;
        return s >>> n;
    endfunction

    task automatic t_reset();
        check("R1", "acc after reset", 32'(acc_q), 32'd0);
        check("R1", "ext after reset", 32'(ext_q), 32'd0);
        check("R1", "busy after reset", 32'(busy), 32'd0);
        check("R1", "done after reset", 32'(done), 32'd0);
    endtask

    task automatic t_shift(input logic left, input logic [11:0] a,
                           input logic [10:0] b, input int n);
        int c;
        logic [22:0] e;
        string req;
        req = left ? "R4" : "R5";
        set_ab(a, b);
        e = model_shift({a, b}, left, n);
        issue(left ? 3'd1 : 3'd2, 5'(n), 12'd0, c);
        check(req, "acc after shift", 32'(acc_q), 32'(e[22:11]));
        check(req, "ext after shift", 32'(ext_q), 32'(e[10:0]));
        check(req, "busy length", 32'(c), 32'(n + 1));
    endtask

    task automatic t_zero(input logic left);
        int c;
        set_ab(12'hA5C, 11'h2D3);
        issue(left ? 3'd1 : 3'd2, 5'd0, 12'd0, c);
        check("R6", "acc zero count", 32'(acc_q), 32'hA5C);
        check("R6", "ext zero count", 32'(ext_q), 32'h2D3);
        check("R6", "busy zero count", 32'(c), 32'd1);
    endtask

    task automatic t_mul(input logic [11:0] a, input logic [11:0] m);
        int c;
        logic [23:0] p;
        set_ab(a, 11'h5A5);
        p = a * m;
        issue(3'd3, 5'd7, m, c);
        check("R7", "acc product", 32'(acc_q), 32'(p[21:11]));
        check("R7", "ext product", 32'(ext_q), 32'(p[10:0]));
        check("R8", "mul busy length", 32'(c), 32'd13);
    endtask

    task automatic t_moves();
        int c;
        set_ab(12'hC3E, 11'h155);
        issue(3'd4, 5'd3, 12'h111, c);
        check("R9", "ext after A to B", 32'(ext_q), 32'h43E);
        check("R9", "acc after A to B", 32'(acc_q), 32'hC3E);
        check("R9", "A to B busy", 32'(c), 32'd1);
        set_ab(12'hFFF, 11'h7A1);
        issue(3'd5, 5'd3, 12'h111, c);
        check("R10", "acc after B to A", 32'(acc_q), 32'h7A1);
        check("R10", "ext after B to A", 32'(ext_q), 32'h7A1);
        check("R10", "B to A busy", 32'(c), 32'd1);
    endtask

    task automatic t_load();
        int c;
        set_ab(12'h000, 11'h3C3);
        issue(3'd6, 5'd9, 12'h9B7, c);
        check("R11", "acc after load", 32'(acc_q), 32'h9B7);
        check("R11", "ext after load", 32'(ext_q), 32'h3C3);
        // R2: a command without strobe is not taken
        @(negedge clk);
        cmd_op = 3'd6; cmd_operand = 12'h123; cmd_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R2", "busy without strobe", 32'(busy), 32'd0);
        check("R2", "acc without strobe", 32'(acc_q), 32'h9B7);
    endtask

    task automatic t_ignore();
        int c;
        logic [22:0] e;
        set_ab(12'h6B2, 11'h0F9);
        e = model_shift({12'h6B2, 11'h0F9}, 1'b1, 9);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd1; cmd_count = 5'd9; cmd_operand = 12'd0;
        @(negedge clk);
        cmd_op = 3'd6; cmd_operand = 12'hEEE; cmd_count = 5'd0;
        c = 0;
        while (busy && c < 100) begin
            c++;
            @(negedge clk);
        end
        check("R12", "busy with commands offered", 32'(c), 32'd10);
        check("R12", "acc at done", 32'(acc_q), 32'(e[22:11]));
        @(negedge clk);
        check("R12", "no start from done cycle", 32'(busy), 32'd0);
        check("R12", "acc after offered load", 32'(acc_q), 32'(e[22:11]));
        check("R12", "ext after offered load", 32'(ext_q), 32'(e[10:0]));
        cmd_valid = 1'b0;
        @(negedge clk);
        check("R12", "still idle", 32'(busy), 32'd0);
    endtask

    task automatic t_nop(input logic [2:0] code);
        int c;
        set_ab(12'h35A, 11'h6C6);
        issue(code, 5'd12, 12'hFFF, c);
        check("R13", "acc after no-op", 32'(acc_q), 32'h35A);
        check("R13", "ext after no-op", 32'(ext_q), 32'h6C6);
        check("R13", "no-op busy", 32'(c), 32'd1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_shift(1'b1, 12'h5A3, 11'h6F1, 3);
        t_shift(1'b1, 12'hFFF, 11'h001, 1);
        t_shift(1'b1, 12'h123, 11'h7FF, 11);
        t_shift(1'b1, 12'h9AB, 11'h555, 23);
        t_shift(1'b1, 12'h001, 11'h400, 31);
        t_shift(1'b0, 12'h5A3, 11'h6F1, 3);
        t_shift(1'b0, 12'h800, 11'h000, 5);
        t_shift(1'b0, 12'hF0F, 11'h2AA, 12);
        t_shift(1'b0, 12'h7FF, 11'h7FF, 22);
        t_shift(1'b0, 12'hA00, 11'h001, 31);
        t_zero(1'b1);
        t_zero(1'b0);
        t_mul(12'h7FF, 12'h7FF);
        t_mul(12'h123, 12'h456);
        t_mul(12'h000, 12'h3AB);
        t_mul(12'h005, 12'h001);
        t_mul(12'h400, 12'h002);
        t_moves();
        t_load();
        t_ignore();
        t_nop(3'd0);
        t_nop(3'd7);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule